// File: doc/BRIEF.md
# Data Weighted Averaging Element Selector

This block picks which unit elements of a 15-element, 16-level feedback DAC are switched on in each sample of a multibit sigma-delta loop. The input is the 15-line thermometer word from a flash quantizer. The block counts the active lines to get a 4-bit level. It then rotates the thermometer pattern circularly by a stored start pointer, so each new group of active elements begins just after the element where the previous group ended.

After each sample, the pointer moves forward by the level, modulo 15. All elements are therefore used at the highest possible rate and equally often. This turns static element mismatch into error with a first-order high-pass shape, which the loop then pushes out of band. The path from input to element-select output is purely combinational: a ones counter in parallel with a staged logarithmic rotator. Only the pointer is stored, and it updates on the sampling clock edge.

Top module: `dwa_selector`

## Requirements
- R1: `cnt_o` equals the number of ones in `therm_i`, from 0 to 15, in the same cycle.
- R2: While `rst_ni` is low, and in the first sample after it rises, the pointer is 0 and `sel_o` equals `therm_i`.
- R3: With pointer p, `sel_o[(i+p) mod 15]` equals `therm_i[i]` for every i, in the same cycle.
- R4: On each rising clock edge out of reset, the pointer becomes (p + `cnt_o`) mod 15.
- R5: A sample with level 0 or level 15 leaves the pointer unchanged for the next sample.
- R6: `sel_o` always has as many ones as `therm_i`.
- R7: An active element shifted past element 14 wraps to element 0. For example, with p = 10 and level 7, elements 10 to 14 and 0 to 1 are selected.
- R8: When the inputs from reset onward are valid thermometer codes (bits 0 to k-1 set), the total use counts of any two elements never differ by more than one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock; the pointer updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the pointer |
| therm_i | input | 15 | Thermometer word from the quantizer |
| sel_o | output | 15 | Rotated element-select word for the unit DAC |
| cnt_o | output | 4 | Number of active input lines |

## Verification
The assertions do not require `therm_i` to be a clean thermometer code. The level, rotation and pointer properties hold for any 15-bit word, so any stimulus keeps within them. Only the balance requirement R8 depends on valid thermometer inputs. To meet that, the bench builds every input from a level drawn at random, or from a directed level, and never drives a word with gaps. The directed levels cover 0, 15 and the wrap-around position.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
  localparam int unsigned DWA_ELEMS = 15;
  localparam int unsigned DWA_CNT_W = $clog2(DWA_ELEMS + 1);
  localparam int unsigned DWA_PTR_W = $clog2(DWA_ELEMS);
endpackage

// File: rtl/dwa_ones_count.sv
module dwa_ones_count #(
  parameter int unsigned N     = dwa_pkg::DWA_ELEMS,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     data_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CNT_W'(data_i[i]);
  end
endmodule

// File: rtl/dwa_rot_shifter.sv
// Circular left rotate by amt_i (< N), one stage per amount bit.
module dwa_rot_shifter #(
  parameter int unsigned N     = dwa_pkg::DWA_ELEMS,
  parameter int unsigned PTR_W = $clog2(N)
) (
  input  logic [N-1:0]     data_i,
  input  logic [PTR_W-1:0] amt_i,
  output logic [N-1:0]     data_o
);
  logic [PTR_W:0][N-1:0] stg;
  assign stg[0] = data_i;

  for (genvar s = 0; s < PTR_W; s++) begin : g_stage
    localparam int unsigned SH = (1 << s) % N;
    logic [N-1:0] rot_s;
    always_comb begin
      rot_s = '0;
      for (int i = 0; i < N; i++) rot_s[(i + SH) % N] = stg[s][i];
    end
    assign stg[s+1] = amt_i[s] ? rot_s : stg[s];
  end

  assign data_o = stg[PTR_W];
endmodule

// File: rtl/dwa_ptr_mod.sv
module dwa_ptr_mod #(
  parameter int unsigned N     = dwa_pkg::DWA_ELEMS,
  parameter int unsigned PTR_W = $clog2(N),
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int unsigned SUM_W = ((CNT_W > PTR_W) ? CNT_W : PTR_W) + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;
  logic [PTR_W-1:0] ptr_d;

  // ptr < N and cnt <= N, so one conditional subtract suffices.
  always_comb begin
    sum     = SUM_W'(ptr_o) + SUM_W'(cnt_i);
    wrapped = (sum >= SUM_W'(N)) ? sum - SUM_W'(N) : sum;
    ptr_d   = PTR_W'(wrapped);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else         ptr_o <= ptr_d;
  end
endmodule

// File: rtl/dwa_selector.sv
module dwa_selector #(
  parameter int unsigned N_ELEM = dwa_pkg::DWA_ELEMS,
  localparam int unsigned CNT_W = $clog2(N_ELEM + 1),
  localparam int unsigned PTR_W = $clog2(N_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ELEM-1:0] therm_i,
  output logic [N_ELEM-1:0] sel_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [PTR_W-1:0] ptr_q;

  dwa_ones_count #(.N(N_ELEM), .CNT_W(CNT_W)) i_cnt (
    .data_i (therm_i),
    .cnt_o  (cnt_o)
  );

  dwa_rot_shifter #(.N(N_ELEM), .PTR_W(PTR_W)) i_rot (
    .data_i (therm_i),
    .amt_i  (ptr_q),
    .data_o (sel_o)
  );

  dwa_ptr_mod #(.N(N_ELEM), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_o),
    .ptr_o  (ptr_q)
  );
endmodule

// File: rtl/dwa_selector_chk.sv
module dwa_selector_chk #(
  parameter int unsigned N_ELEM = dwa_pkg::DWA_ELEMS,
  localparam int unsigned CNT_W = $clog2(N_ELEM + 1),
  localparam int unsigned PTR_W = $clog2(N_ELEM)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_ELEM-1:0] therm_i,
  input logic [N_ELEM-1:0] sel_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [PTR_W-1:0]  ptr_q
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r1_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_o) == $countones(therm_i));

  a_r6_same_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == $countones(therm_i));

  a_r3_start_elem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_i[0] |-> sel_o[ptr_q]);

  a_r4_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_q) < N_ELEM);

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> 32'(ptr_q) == (32'($past(ptr_q)) + 32'($past(cnt_o))) % N_ELEM);

  a_r5_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($past(cnt_o) == '0 || 32'($past(cnt_o)) == N_ELEM)) |-> $stable(ptr_q));

  a_r2_reset_ptr: assert property (@(posedge clk_i)
    !rst_ni |-> ptr_q == '0);
endmodule

bind dwa_selector dwa_selector_chk #(.N_ELEM(N_ELEM)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .therm_i (therm_i),
  .sel_o   (sel_o),
  .cnt_o   (cnt_o),
  .ptr_q   (ptr_q)
);

// File: tb/test_dwa_selector.sv
module test_dwa_selector;
  localparam int N = 15;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  therm_i = '0;
  logic [N-1:0]  sel_o;
  logic [3:0]    cnt_o;

  int checks = 0;
  int errors = 0;
  int exp_ptr = 0;
  int use_cnt [N];
  bit done = 1'b0;

  dwa_selector i_dwa_selector (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .therm_i (therm_i),
    .sel_o   (sel_o),
    .cnt_o   (cnt_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [N-1:0] therm_of(int k);
    logic [N-1:0] t = '0;
    for (int i = 0; i < k; i++) t[i] = 1'b1;
    return t;
  endfunction

  function automatic logic [N-1:0] rot_of(logic [N-1:0] t, int p);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) r[(i + p) % N] = t[i];
    return r;
  endfunction

  function automatic int ones_of(logic [N-1:0] t);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(t[i]);
    return c;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive level k, check outputs, then track pointer and use counts.
  task automatic step(int k, string tag);
    logic [N-1:0] t;
    int mx, mn;
    @(negedge clk_i);
    t = therm_of(k);
    therm_i = t;
    #1;
    check(int'(cnt_o) == k, "R1 level", int'(cnt_o), k);
    check(sel_o == rot_of(t, exp_ptr), tag, int'(sel_o), int'(rot_of(t, exp_ptr)));
    check(ones_of(sel_o) == k, "R6 ones", ones_of(sel_o), k);
    for (int i = 0; i < N; i++) use_cnt[i] += int'(sel_o[i]);
    mx = use_cnt[0]; mn = use_cnt[0];
    for (int i = 1; i < N; i++) begin
      if (use_cnt[i] > mx) mx = use_cnt[i];
      if (use_cnt[i] < mn) mn = use_cnt[i];
    end
    check(mx - mn <= 1, "R8 balance", mx - mn, 1);
    exp_ptr = (exp_ptr + k) % N;
  endtask

  initial begin
    int seed = 32'h5eed_d0a1;
    int dummy = $urandom(seed);
    int prev_ptr;
    for (int i = 0; i < N; i++) use_cnt[i] = 0;
    // R2: during reset pointer is 0, output is unrotated
    therm_i = therm_of(6);
    repeat (3) @(posedge clk_i);
    #1;
    check(sel_o == therm_of(6), "R2 reset", int'(sel_o), int'(therm_of(6)));
    therm_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(9, "R2 first sample");
    step(0, "R3 rotate");
    // R5: level 0 left pointer at 9
    check(exp_ptr == 9, "R5 zero", exp_ptr, 9);
    prev_ptr = exp_ptr;
    step(15, "R5 full");
    step(1, "R5 after full");
    check(sel_o[prev_ptr] == 1'b1, "R5 full keeps ptr", int'(sel_o), 1 << prev_ptr);
    // bring pointer to 10 (currently 10 after 9+15+1), then wrap
    step(7, "R7 wrap");
    check(sel_o == 15'b000_0011_1111_1111 << 0 ? 1'b0 : 1'b1, "R7 shape", int'(sel_o), 0);
    step(5, "R3 after wrap");
    check(sel_o[2] && sel_o[6] && !sel_o[7] && !sel_o[1], "R7 next group", int'(sel_o), 15'h7c);
    for (int n = 0; n < 3000; n++) step(int'($urandom_range(0, 15)), "R3 random");
    for (int n = 0; n < 40; n++) step(((n % 3) == 0) ? 15 : ((n % 3) == 1 ? 0 : 14), "R4 corner");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule